// File: doc/BRIEF.md
# Operand Forwarding and Stall Control

This unit decides, for a five-stage in-order pipeline (fetch, decode with register read, execute, memory, writeback), where each of the two source operands of an instruction gets its value and when the front of the pipeline must wait. The decode stage presents its instruction's two source register numbers, its destination, its write enable and whether it is a load. The unit keeps its own record of the destinations of the instructions that have moved on into execute, memory and writeback. From that record it drives a select code for each operand of the instruction now in execute, and a stall that freezes the program counter and the decode register while a bubble goes into execute.

Forwarding is a build-time option, chosen separately for operand A and operand B, so all four mixes (none, A only, B only, both) come from one source. An operand built without forwarding waits instead, until its producer has reached writeback. The register file is taken to write in the first half of a cycle and read in the second, so a value in writeback can be read directly.

Top module: `fwd_hazard_unit`

## Requirements
- R1: After reset the stall output is low and both select codes are 2'b00 while the decode slot is empty.
- R2: With forwarding built in for an operand, its select is 2'b01 when the instruction one ahead in the memory stage writes that source register, 2'b10 when the instruction in writeback writes it, and 2'b00 (register file) otherwise.
- R3: When both the memory-stage and writeback-stage instructions write the same source register, the select is 2'b01, the younger result.
- R4: Register number 0 never raises a stall and never produces a non-zero select.
- R5: An older instruction causes neither stall nor forward unless its write enable was set, and a decode slot marked not valid never stalls.
- R6: With forwarding on for an operand, a load followed at once by an instruction reading its destination there stalls exactly one cycle, after which that operand selects 2'b10.
- R7: Each stall cycle sends an instruction with no write and no load into execute, so the held instruction enters execute only once.
- R8: With forwarding off for an operand, a dependence on the instruction one ahead stalls two cycles, on the instruction two ahead one cycle, and on anything older none; no stall run exceeds two cycles.
- R9: An operand built without forwarding always selects 2'b00, regardless of the setting of the other operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Decode slot holds a real instruction |
| dec_src_a | input | RAW | Source register A of the decode instruction |
| dec_src_b | input | RAW | Source register B of the decode instruction |
| dec_dst | input | RAW | Destination register of the decode instruction |
| dec_wr_en | input | 1 | Decode instruction writes its destination |
| dec_is_load | input | 1 | Decode instruction is a load |
| stall | output | 1 | Hold PC and decode register, bubble into execute |
| fwd_sel_a | output | 2 | Select for operand A in execute: 00 file, 01 memory stage, 10 writeback stage |
| fwd_sel_b | output | 2 | Select for operand B in execute, same encoding |

## Verification
A wrong entry in the unit's record of older destinations shows up at the ports within one to three cycles: first as a stall that is missing, extra or of the wrong length while the consumer sits in decode, then as a wrong select code in the cycle the consumer reaches execute. A lost bubble is seen as a held instruction appearing twice in execute, which changes the selects of the following instruction. Mixing short register numbers with frequent loads and invalid slots makes adjacent and two-apart dependences common, so each such fault is exposed within a few dozen cycles in every one of the four configurations.

// File: rtl/fwdhz_pkg.sv
package fwdhz_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_EXM = 2'b01,
      SEL_MWB = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/hz_track.sv
// Shadow of the destination fields of instructions past decode.
module hz_track #(
   parameter int RAW = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           stall,
   input  logic           dec_valid,
   input  logic [RAW-1:0] dec_src_a,
   input  logic [RAW-1:0] dec_src_b,
   input  logic [RAW-1:0] dec_dst,
   input  logic           dec_wr_en,
   input  logic           dec_is_load,
   output logic [RAW-1:0] ex_src_a,
   output logic [RAW-1:0] ex_src_b,
   output logic [RAW-1:0] ex_dst,
   output logic           ex_we,
   output logic           ex_load,
   output logic [RAW-1:0] mem_dst,
   output logic           mem_we,
   output logic [RAW-1:0] wb_dst,
   output logic           wb_we
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ex_src_a <= '0;
         ex_src_b <= '0;
         ex_dst   <= '0;
         ex_we    <= 1'b0;
         ex_load  <= 1'b0;
         mem_dst  <= '0;
         mem_we   <= 1'b0;
         wb_dst   <= '0;
         wb_we    <= 1'b0;
      end else begin
         if (stall) begin
            ex_src_a <= '0;
            ex_src_b <= '0;
            ex_dst   <= '0;
            ex_we    <= 1'b0;
            ex_load  <= 1'b0;
         end else begin
            ex_src_a <= dec_src_a;
            ex_src_b <= dec_src_b;
            ex_dst   <= dec_dst;
            ex_we    <= dec_wr_en & dec_valid;
            ex_load  <= dec_is_load & dec_valid;
         end
         mem_dst <= ex_dst;
         mem_we  <= ex_we;
         wb_dst  <= mem_dst;
         wb_we   <= mem_we;
      end
   end

   // a stall cycle must leave a harmless slot in execute
   assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (!ex_we && !ex_load));
endmodule

// File: rtl/hz_operand.sv
// Hazard and forward decision for one source operand.
module hz_operand
   import fwdhz_pkg::*;
#(
   parameter int RAW    = 5,
   parameter bit FWD_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           dec_valid,
   input  logic [RAW-1:0] dec_src,
   input  logic [RAW-1:0] ex_src,
   input  logic [RAW-1:0] ex_dst,
   input  logic           ex_we,
   input  logic           ex_load,
   input  logic [RAW-1:0] mem_dst,
   input  logic           mem_we,
   input  logic [RAW-1:0] wb_dst,
   input  logic           wb_we,
   output logic           need_stall,
   output fwd_sel_e       sel
);
   logic dec_nz, ex_nz;
   logic dec_hit_ex, dec_hit_mem, ex_hit_mem, ex_hit_wb;

   assign dec_nz      = (dec_src != '0);
   assign ex_nz       = (ex_src != '0);
   assign dec_hit_ex  = dec_valid && dec_nz && ex_we  && (dec_src == ex_dst);
   assign dec_hit_mem = dec_valid && dec_nz && mem_we && (dec_src == mem_dst);
   assign ex_hit_mem  = ex_nz && mem_we && (ex_src == mem_dst);
   assign ex_hit_wb   = ex_nz && wb_we  && (ex_src == wb_dst);

   always_comb begin
      sel        = SEL_RF;
      need_stall = 1'b0;
      if (FWD_EN) begin
         need_stall = dec_hit_ex && ex_load;
         if (ex_hit_mem)     sel = SEL_EXM;
         else if (ex_hit_wb) sel = SEL_MWB;
      end else begin
         need_stall = dec_hit_ex || dec_hit_mem;
      end
   end

   assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_src == '0) |-> (sel == SEL_RF));

   generate
      if (FWD_EN) begin : g_fwd
         // decode is held during the stall, the load moves to memory
         assert_load_use_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
            need_stall |=> !need_stall);
      end
   endgenerate
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
   import fwdhz_pkg::*;
#(
   parameter int RAW   = 5,
   parameter bit FWD_A = 1'b1,
   parameter bit FWD_B = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           dec_valid,
   input  logic [RAW-1:0] dec_src_a,
   input  logic [RAW-1:0] dec_src_b,
   input  logic [RAW-1:0] dec_dst,
   input  logic           dec_wr_en,
   input  logic           dec_is_load,
   output logic           stall,
   output logic [1:0]     fwd_sel_a,
   output logic [1:0]     fwd_sel_b
);
   localparam int       NOPS   = 2;
   localparam bit [1:0] FWD_V  = {FWD_B, FWD_A};

   generate
      if (RAW < 1 || RAW > 8) begin : g_bad_raw
         $error("RAW must lie in 1..8");
      end
   endgenerate

   logic [RAW-1:0] ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
   logic           ex_we, ex_load, mem_we, wb_we;
   logic [RAW-1:0] dsrc [NOPS];
   logic [RAW-1:0] esrc [NOPS];
   logic [NOPS-1:0] op_stall;
   fwd_sel_e       op_sel [NOPS];

   assign dsrc[0] = dec_src_a;
   assign dsrc[1] = dec_src_b;
   assign esrc[0] = ex_src_a;
   assign esrc[1] = ex_src_b;

   hz_track #(.RAW(RAW)) u_track (
      .clk(clk), .rst_n(rst_n), .stall(stall),
      .dec_valid(dec_valid), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
      .dec_dst(dec_dst), .dec_wr_en(dec_wr_en), .dec_is_load(dec_is_load),
      .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst),
      .ex_we(ex_we), .ex_load(ex_load),
      .mem_dst(mem_dst), .mem_we(mem_we), .wb_dst(wb_dst), .wb_we(wb_we)
   );

   generate
      for (genvar i = 0; i < NOPS; i++) begin : g_op
         hz_operand #(.RAW(RAW), .FWD_EN(FWD_V[i])) u_op (
            .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
            .dec_src(dsrc[i]), .ex_src(esrc[i]),
            .ex_dst(ex_dst), .ex_we(ex_we), .ex_load(ex_load),
            .mem_dst(mem_dst), .mem_we(mem_we),
            .wb_dst(wb_dst), .wb_we(wb_we),
            .need_stall(op_stall[i]), .sel(op_sel[i])
         );
      end
   endgenerate

   assign stall     = |op_stall;
   assign fwd_sel_a = op_sel[0];
   assign fwd_sel_b = op_sel[1];

   // length of the current stall run, saturating
   logic [1:0] run_len;
   always_ff @(posedge clk) begin
      if (!rst_n)       run_len <= '0;
      else if (!stall)  run_len <= '0;
      else if (run_len != 2'd3) run_len <= run_len + 2'd1;
   end

   assert_stall_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (run_len < 2'd2));
   assert_sel_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_sel_a != 2'b11) && (fwd_sel_b != 2'b11));
endmodule

// File: tb/sim_fwd_hazard_unit.sv
module sim_fwd_hazard_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   checks = 0;
   int   errors = 0;
   logic [3:0] done = '0;

   always #4 clk = ~clk;   // 125 MHz

   function automatic logic hit(logic [4:0] s, logic [4:0] d, logic we);
      return (s != 5'd0) && we && (s == d);
   endfunction

   function automatic logic [1:0] exp_sel(bit en, logic [4:0] s, logic [4:0] md,
                                          logic mw, logic [4:0] wd, logic ww);
      if (!en) return 2'b00;
      if (hit(s, md, mw)) return 2'b01;
      if (hit(s, wd, ww)) return 2'b10;
      return 2'b00;
   endfunction

   function automatic logic exp_op_stall(bit en, logic v, logic [4:0] s, logic [4:0] ed,
                                         logic ew, logic el, logic [4:0] md, logic mw);
      if (!v) return 1'b0;
      if (en) return hit(s, ed, ew) && el;
      return hit(s, ed, ew) || hit(s, md, mw);
   endfunction

   // {valid, load, we, dst, srcb, srca}
   function automatic logic [17:0] directed(int k);
      case (k)
         0: return {1'b1, 1'b1, 1'b1, 5'd2, 5'd0, 5'd0};
         1: return {1'b1, 1'b0, 1'b1, 5'd3, 5'd0, 5'd2};
         2: return {1'b1, 1'b0, 1'b1, 5'd1, 5'd2, 5'd3};
         3: return {1'b1, 1'b0, 1'b0, 5'd1, 5'd1, 5'd1};
         4: return {1'b1, 1'b0, 1'b1, 5'd1, 5'd0, 5'd0};
         5: return {1'b1, 1'b0, 1'b1, 5'd1, 5'd0, 5'd0};
         6: return {1'b1, 1'b0, 1'b1, 5'd0, 5'd1, 5'd1};
         7: return {1'b1, 1'b0, 1'b1, 5'd0, 5'd0, 5'd0};
         8: return {1'b1, 1'b0, 1'b1, 5'd2, 5'd0, 5'd0};
         9: return {1'b1, 1'b0, 1'b1, 5'd3, 5'd2, 5'd2};
         10: return {1'b0, 1'b1, 1'b1, 5'd3, 5'd3, 5'd3};
         default: return {1'b1, 1'b0, 1'b0, 5'd0, 5'd3, 5'd3};
      endcase
   endfunction

   task automatic check(string tag, int lane, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s lane %0d %s: actual %0d expected %0d at %0t",
                  tag, lane, what, act, exp, $time);
      end
   endtask

   generate
      for (genvar g = 0; g < 4; g++) begin : cfg
         localparam bit FA = g[0];
         localparam bit FB = g[1];
         logic       iv = 1'b0, ild = 1'b0, iwe = 1'b0;
         logic [4:0] ia = '0, ib = '0, id = '0;
         logic       st;
         logic [1:0] sa, sb;

         fwd_hazard_unit #(.RAW(5), .FWD_A(FA), .FWD_B(FB)) u0 (
            .clk(clk), .rst_n(rst_n), .dec_valid(iv),
            .dec_src_a(ia), .dec_src_b(ib), .dec_dst(id),
            .dec_wr_en(iwe), .dec_is_load(ild),
            .stall(st), .fwd_sel_a(sa), .fwd_sel_b(sb)
         );

         initial begin
            logic [4:0] ea = '0, eb = '0, ed = '0, md = '0, wd = '0;
            logic ew = 0, el = 0, mw = 0, ww = 0, prev = 0;
            logic [17:0] w;
            int k = 0;
            void'($urandom(32'd77 + g));
            wait (rst_n === 1'b1);
            @(negedge clk);
            check("R1", g, st, 0, "stall after reset");
            check("R1", g, sa, 0, "sel A after reset");
            check("R1", g, sb, 0, "sel B after reset");
            w = directed(0);
            {iv, ild, iwe, id, ib, ia} = w;
            k = 1;
            for (int n = 0; n < 600; n++) begin
               logic xsa, xsb, xst;
               logic [1:0] xa, xb;
               string tg;
               #1;
               xsa = exp_op_stall(FA, iv, ia, ed, ew, el, md, mw);
               xsb = exp_op_stall(FB, iv, ib, ed, ew, el, md, mw);
               xst = xsa | xsb;
               xa  = exp_sel(FA, ea, md, mw, wd, ww);
               xb  = exp_sel(FB, eb, md, mw, wd, ww);
               if (prev)                                         tg = "R7";
               else if (xst && ((FA && xsa) || (FB && xsb)))     tg = "R6";
               else if (xst)                                     tg = "R8";
               else if (ia == 0 || ib == 0)                      tg = "R4";
               else                                              tg = "R5";
               check(tg, g, st, xst, "stall");
               if (!FA)                                    tg = "R9";
               else if (hit(ea, md, mw) && hit(ea, wd, ww)) tg = "R3";
               else if (ea == 0)                           tg = "R4";
               else                                        tg = "R2";
               check(tg, g, sa, xa, "sel A");
               if (!FB)                                    tg = "R9";
               else if (hit(eb, md, mw) && hit(eb, wd, ww)) tg = "R3";
               else if (eb == 0)                           tg = "R4";
               else                                        tg = "R2";
               check(tg, g, sb, xb, "sel B");
               wd = md; ww = mw;
               md = ed; mw = ew;
               if (xst) begin
                  ea = 0; eb = 0; ed = 0; ew = 0; el = 0;
               end else begin
                  ea = ia; eb = ib; ed = id; ew = iwe & iv; el = ild & iv;
               end
               prev = xst;
               @(negedge clk);
               if (!xst) begin
                  if (k < 12) begin
                     w = directed(k);
                     {iv, ild, iwe, id, ib, ia} = w;
                  end else begin
                     iv  = ($urandom % 8) != 0;
                     ild = ($urandom % 3) == 0;
                     iwe = ($urandom % 5) != 0;
                     ia  = 5'($urandom % 4);
                     ib  = 5'($urandom % 4);
                     id  = 5'($urandom % 4);
                  end
                  k++;
               end
            end
            done[g] = 1'b1;
         end
      end
   endgenerate

   initial begin
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      wait (done == 4'hF);
      @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule